// File: doc/BRIEF.md
# I2C Controller FIFO and Interrupt Status Unit

This block holds the word-wide transmit and receive FIFOs of an I2C controller and the control, status, mask and interrupt-status registers around them. Software reaches everything through a small 32-bit register port with one-cycle write and read strobes. A transfer engine sits on the other side. It drains transmit words, supplies received words, and pulses four event lines: packet done, all packets done, missing acknowledge and lost arbitration.

Each FIFO reports how full it is. Software sets a trigger level for each direction, and the two data-request interrupts follow those levels. Each FIFO can be emptied through a flush bit that clears itself once the flush has completed. All eight interrupt sources are latched in a status register that software clears by writing ones. A mask register selects which latched sources drive the single interrupt line.

Register word addresses on `reg_addr`: 0 transmit data (write), 1 receive data (read), 2 FIFO control, 3 FIFO status, 4 interrupt mask, 5 interrupt status.

Top module: `i2cfs_unit`

## Requirements
- R1: FIFO status (address 3) reads the transmit free slots in bits 7:4 and the receive words available in bits 3:0. Each FIFO holds 8 words, so the value after reset is 0x80.
- R2: Writing 1 to FIFO control bit 1 flushes the transmit FIFO, and writing 1 to bit 0 flushes the receive FIFO. In the cycle after the write the bit reads 1, the FIFO is then emptied, and from the following cycle the bit reads 0.
- R3: FIFO control holds the transmit trigger level in bits 7:5 and the receive trigger level in bits 4:2. Both read back as written and reset to 0.
- R4: Interrupt status (address 5) bit positions are: 7 packet done, 6 all packets done, 5 transmit overflow, 4 receive underflow, 3 no acknowledge, 2 arbitration lost, 1 transmit data request, 0 receive data request. A one-cycle event pulse sets its bit at the next clock edge.
- R5: Writing a value to interrupt status clears the bits that are 1 in that value. If a source sets a bit in the same cycle that the write clears it, the bit stays set.
- R6: Reading receive data (address 1) returns words in arrival order and removes one word per read. A read of an empty receive FIFO returns 0 and sets status bit 4.
- R7: Writes to transmit data (address 0) reach the engine in write order. A write to a full transmit FIFO is dropped and sets status bit 5.
- R8: Status bit 1 is set in every cycle in which the transmit free slots exceed the transmit trigger level. Status bit 0 is set in every cycle in which the receive words available exceed the receive trigger level.
- R9: The interrupt mask (address 4) uses the status bit layout, resets to 0, and reads back as written. `irq` is 1 exactly when some status bit and its mask bit are both 1.
- R10: Clearing a mask bit leaves the latched status bit unchanged and only removes its effect on `irq`.
- R11: Reading address 0, or any address above 5, returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops receive data at address 1) |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the strobe cycle |
| eng_tx_pop | input | 1 | Engine takes the transmit head word |
| eng_tx_data | output | 32 | Transmit head word |
| eng_tx_valid | output | 1 | Transmit FIFO not empty |
| eng_rx_push | input | 1 | Engine delivers a received word (ignored when full) |
| eng_rx_data | input | 32 | Received word |
| evt_pkt_done | input | 1 | Packet complete pulse |
| evt_all_done | input | 1 | All packets complete pulse |
| evt_nak | input | 1 | No acknowledge pulse |
| evt_arb_lost | input | 1 | Arbitration lost pulse |
| irq | output | 1 | Interrupt request |

## Verification
The risky coincidence is an event that sets a status bit landing in the same cycle as the software write that clears that bit. The bench pulses the packet-done line in exactly the cycle of a write-one-to-clear of bit 7, then reads the status back. The bit must still be set, while bits cleared without a coincident event must read 0. A second case is a level-driven data request that stays true across its own clear: after the clear, the bench expects the transmit request bit to read 1 again, because its condition still holds.

// File: rtl/i2cfs_pkg.sv
package i2cfs_pkg;
  localparam int REG_AW = 3;
  localparam int IRQ_N  = 8;
  localparam int TRIG_W = 3;

  typedef enum logic [REG_AW-1:0] {
    A_TXDATA = 3'd0,
    A_RXDATA = 3'd1,
    A_FCTL   = 3'd2,
    A_FSTAT  = 3'd3,
    A_IMASK  = 3'd4,
    A_ISTAT  = 3'd5
  } reg_addr_e;

  // interrupt bit positions (decoded by software)
  localparam int IB_PKT   = 7;
  localparam int IB_ALL   = 6;
  localparam int IB_TXOVF = 5;
  localparam int IB_RXUDF = 4;
  localparam int IB_NAK   = 3;
  localparam int IB_ARB   = 2;
  localparam int IB_TXREQ = 1;
  localparam int IB_RXREQ = 0;

  // FIFO control field positions
  localparam int CB_TXFL     = 1;
  localparam int CB_RXFL     = 0;
  localparam int TXTRIG_LSB  = 5;
  localparam int RXTRIG_LSB  = 2;
endpackage

// File: rtl/i2cfs_word_fifo.sv
module i2cfs_word_fifo #(
  parameter  int DEPTH = 8,
  parameter  int WIDTH = 32,
  localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic [CW-1:0]    count,
  output logic             full,
  output logic             empty
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PW-1:0]    wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             do_push, do_pop;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full  = (cnt_q == CW'(DEPTH));
  assign empty = (cnt_q == '0);
  assign count = cnt_q;
  assign head  = mem_q[rd_q];

  // flush has priority over both sides
  assign do_push = push && !full  && !flush;
  assign do_pop  = pop  && !empty && !flush;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (flush) begin
      wr_d  = '0;
      rd_d  = '0;
      cnt_d = '0;
    end else begin
      if (do_push) wr_d = ptr_inc(wr_q);
      if (do_pop)  rd_d = ptr_inc(rd_q);
      cnt_d = cnt_q + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  // storage carries no reset; written only under its enable
  always_ff @(posedge clk) begin
    if (do_push) mem_q[wr_q] <= push_data;
  end
endmodule

// File: rtl/i2cfs_fifo_ctl.sv
module i2cfs_fifo_ctl
  import i2cfs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [7:0]        wdata,
  output logic [TRIG_W-1:0] tx_trig,
  output logic [TRIG_W-1:0] rx_trig,
  output logic              tx_flush,
  output logic              rx_flush
);
  logic [TRIG_W-1:0] txt_q, txt_d, rxt_q, rxt_d;
  logic              txf_q, txf_d, rxf_q, rxf_d;

  always_comb begin
    txt_d = txt_q;
    rxt_d = rxt_q;
    // flush request lives one cycle, the FIFO empties in that cycle
    txf_d = 1'b0;
    rxf_d = 1'b0;
    if (we) begin
      txt_d = wdata[TXTRIG_LSB +: TRIG_W];
      rxt_d = wdata[RXTRIG_LSB +: TRIG_W];
      txf_d = wdata[CB_TXFL];
      rxf_d = wdata[CB_RXFL];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txt_q <= '0;
      rxt_q <= '0;
      txf_q <= 1'b0;
      rxf_q <= 1'b0;
    end else begin
      txt_q <= txt_d;
      rxt_q <= rxt_d;
      txf_q <= txf_d;
      rxf_q <= rxf_d;
    end
  end

  assign tx_trig  = txt_q;
  assign rx_trig  = rxt_q;
  assign tx_flush = txf_q;
  assign rx_flush = rxf_q;
endmodule

// File: rtl/i2cfs_irq_ctrl.sv
module i2cfs_irq_ctrl #(
  parameter int NBITS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NBITS-1:0] set_vec,
  input  logic             clr_en,
  input  logic [NBITS-1:0] clr_vec,
  input  logic             mask_we,
  input  logic [NBITS-1:0] mask_wdata,
  output logic [NBITS-1:0] stat,
  output logic [NBITS-1:0] mask,
  output logic             irq
);
  logic [NBITS-1:0] stat_q, stat_d, mask_q, mask_d;

  always_comb begin
    // a set in the same cycle as a clear wins
    stat_d = (stat_q & ~(clr_en ? clr_vec : '0)) | set_vec;
    mask_d = mask_we ? mask_wdata : mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      mask_q <= '0;
    end else begin
      stat_q <= stat_d;
      mask_q <= mask_d;
    end
  end

  assign stat = stat_q;
  assign mask = mask_q;
  assign irq  = |(stat_q & mask_q);
endmodule

// File: rtl/i2cfs_unit.sv
module i2cfs_unit
  import i2cfs_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int FIFO_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              eng_tx_pop,
  output logic [DATA_W-1:0] eng_tx_data,
  output logic              eng_tx_valid,
  input  logic              eng_rx_push,
  input  logic [DATA_W-1:0] eng_rx_data,
  input  logic              evt_pkt_done,
  input  logic              evt_all_done,
  input  logic              evt_nak,
  input  logic              evt_arb_lost,
  output logic              irq
);
  localparam int CW = $clog2(FIFO_DEPTH + 1);

  logic [CW-1:0]     tx_cnt, rx_cnt, tx_free;
  logic              tx_full, tx_empty, rx_full, rx_empty;
  logic [DATA_W-1:0] rx_head;
  logic [TRIG_W-1:0] tx_trig, rx_trig;
  logic              tx_flush, rx_flush;
  logic [IRQ_N-1:0]  int_stat, int_mask, set_vec;
  logic              tx_push, rx_pop, ctl_we, mask_we, stat_we;
  logic              tx_req, rx_req;

  assign tx_push = reg_wr && (reg_addr == A_TXDATA);
  assign rx_pop  = reg_rd && (reg_addr == A_RXDATA);
  assign ctl_we  = reg_wr && (reg_addr == A_FCTL);
  assign mask_we = reg_wr && (reg_addr == A_IMASK);
  assign stat_we = reg_wr && (reg_addr == A_ISTAT);

  i2cfs_fifo_ctl u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (ctl_we),
    .wdata    (reg_wdata[7:0]),
    .tx_trig  (tx_trig),
    .rx_trig  (rx_trig),
    .tx_flush (tx_flush),
    .rx_flush (rx_flush)
  );

  i2cfs_word_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(DATA_W)) u_txf (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (tx_flush),
    .push      (tx_push),
    .push_data (reg_wdata),
    .pop       (eng_tx_pop),
    .head      (eng_tx_data),
    .count     (tx_cnt),
    .full      (tx_full),
    .empty     (tx_empty)
  );

  i2cfs_word_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(DATA_W)) u_rxf (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (rx_flush),
    .push      (eng_rx_push),
    .push_data (eng_rx_data),
    .pop       (rx_pop),
    .head      (rx_head),
    .count     (rx_cnt),
    .full      (rx_full),
    .empty     (rx_empty)
  );

  assign eng_tx_valid = !tx_empty;
  assign tx_free      = CW'(FIFO_DEPTH) - tx_cnt;
  assign tx_req       = 32'(tx_free) > 32'(tx_trig);
  assign rx_req       = 32'(rx_cnt)  > 32'(rx_trig);

  always_comb begin
    set_vec           = '0;
    set_vec[IB_PKT]   = evt_pkt_done;
    set_vec[IB_ALL]   = evt_all_done;
    set_vec[IB_TXOVF] = tx_push && tx_full;
    set_vec[IB_RXUDF] = rx_pop && rx_empty;
    set_vec[IB_NAK]   = evt_nak;
    set_vec[IB_ARB]   = evt_arb_lost;
    set_vec[IB_TXREQ] = tx_req;
    set_vec[IB_RXREQ] = rx_req;
  end

  i2cfs_irq_ctrl #(.NBITS(IRQ_N)) u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_vec    (set_vec),
    .clr_en     (stat_we),
    .clr_vec    (reg_wdata[IRQ_N-1:0]),
    .mask_we    (mask_we),
    .mask_wdata (reg_wdata[IRQ_N-1:0]),
    .stat       (int_stat),
    .mask       (int_mask),
    .irq        (irq)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_RXDATA: reg_rdata = rx_empty ? '0 : rx_head;
      A_FCTL:   reg_rdata = DATA_W'({tx_trig, rx_trig, tx_flush, rx_flush});
      A_FSTAT:  reg_rdata = DATA_W'({4'(tx_free), 4'(rx_cnt)});
      A_IMASK:  reg_rdata = DATA_W'(int_mask);
      A_ISTAT:  reg_rdata = DATA_W'(int_stat);
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/i2cfs_unit_chk.sv
module i2cfs_unit_chk
  import i2cfs_pkg::*;
#(
  parameter  int DEPTH = 8,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [REG_AW-1:0] reg_addr,
  input logic [31:0]       reg_rdata,
  input logic              eng_tx_pop,
  input logic              evt_nak,
  input logic              irq,
  input logic [IRQ_N-1:0]  int_stat,
  input logic [IRQ_N-1:0]  int_mask,
  input logic [CW-1:0]     tx_cnt,
  input logic [CW-1:0]     rx_cnt,
  input logic              tx_flush,
  input logic              rx_flush
);
  assert_count_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_cnt <= CW'(DEPTH)) && (rx_cnt <= CW'(DEPTH)));

  assert_tx_flush_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_flush |=> (tx_cnt == '0));

  assert_rx_flush_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_flush |=> (rx_cnt == '0));

  assert_underflow_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == A_RXDATA && rx_cnt == '0) |-> (reg_rdata == '0));

  assert_underflow_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == A_RXDATA && rx_cnt == '0) |=> int_stat[IB_RXUDF]);

  assert_overflow_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_TXDATA && tx_cnt == CW'(DEPTH) && !tx_flush && !eng_tx_pop)
    |=> (int_stat[IB_TXOVF] && tx_cnt == CW'(DEPTH)));

  assert_nak_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_nak && int_mask[IB_NAK] && !(reg_wr && reg_addr == A_IMASK)) |=> irq);

  assert_mask_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == A_IMASK) |=> $stable(int_mask));

  assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (int_stat[IB_NAK] && !(reg_wr && reg_addr == A_ISTAT)) |=> int_stat[IB_NAK]);
endmodule

bind i2cfs_unit i2cfs_unit_chk #(.DEPTH(FIFO_DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_wr     (reg_wr),
  .reg_rd     (reg_rd),
  .reg_addr   (reg_addr),
  .reg_rdata  (reg_rdata),
  .eng_tx_pop (eng_tx_pop),
  .evt_nak    (evt_nak),
  .irq        (irq),
  .int_stat   (int_stat),
  .int_mask   (int_mask),
  .tx_cnt     (tx_cnt),
  .rx_cnt     (rx_cnt),
  .tx_flush   (tx_flush),
  .rx_flush   (rx_flush)
);

// File: tb/i2cfs_unit_tb.sv
module i2cfs_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr, reg_rd;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        eng_tx_pop, eng_tx_valid, eng_rx_push;
  logic [31:0] eng_tx_data, eng_rx_data;
  logic        evt_pkt_done, evt_all_done, evt_nak, evt_arb_lost, irq;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  i2cfs_unit u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .eng_tx_pop(eng_tx_pop), .eng_tx_data(eng_tx_data), .eng_tx_valid(eng_tx_valid),
    .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data),
    .evt_pkt_done(evt_pkt_done), .evt_all_done(evt_all_done),
    .evt_nak(evt_nak), .evt_arb_lost(evt_arb_lost), .irq(irq)
  );

  // word addresses: 0 TX data, 1 RX data, 2 ctl, 3 FIFO status, 4 mask, 5 int status
  typedef struct packed {
    logic        rd;
    logic [2:0]  addr;
    logic [31:0] data;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 31;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 3'd4, 32'h00,   4'd9},  // R9 mask stays zero
    '{1'b0, 3'd2, 32'h00,   4'd3},  // R3 triggers 0
    '{1'b0, 3'd0, 32'hA1,   4'd7},
    '{1'b0, 3'd0, 32'hA2,   4'd7},
    '{1'b0, 3'd0, 32'hA3,   4'd7},
    '{1'b1, 3'd3, 32'h50,   4'd1},  // R1 5 free, 0 avail
    '{1'b0, 3'd2, 32'h02,   4'd2},  // R2 flush transmit
    '{1'b1, 3'd2, 32'h02,   4'd2},  // R2 flush bit visible
    '{1'b1, 3'd2, 32'h00,   4'd2},  // R2 self cleared
    '{1'b1, 3'd3, 32'h80,   4'd2},  // R2 transmit emptied
    '{1'b0, 3'd2, 32'hAC,   4'd3},  // R3 tx trig 5, rx trig 3
    '{1'b1, 3'd2, 32'hAC,   4'd3},
    '{1'b1, 3'd1, 32'h00,   4'd6},  // R6 empty read gives 0
    '{1'b1, 3'd5, 32'h12,   4'd6},  // R6 underflow + R8 tx request
    '{1'b0, 3'd5, 32'h12,   4'd5},
    '{1'b1, 3'd5, 32'h02,   4'd5},  // R5 tx request re-set, underflow gone
    '{1'b0, 3'd0, 32'hB0,   4'd7},
    '{1'b0, 3'd0, 32'hB1,   4'd7},
    '{1'b0, 3'd0, 32'hB2,   4'd7},
    '{1'b0, 3'd0, 32'hB3,   4'd7},
    '{1'b0, 3'd0, 32'hB4,   4'd7},
    '{1'b0, 3'd0, 32'hB5,   4'd7},
    '{1'b0, 3'd0, 32'hB6,   4'd7},
    '{1'b0, 3'd0, 32'hB7,   4'd7},
    '{1'b0, 3'd0, 32'hDEAD, 4'd7},  // R7 dropped
    '{1'b1, 3'd3, 32'h00,   4'd1},  // R1 full
    '{1'b1, 3'd5, 32'h22,   4'd7},  // R7 overflow flag
    '{1'b0, 3'd5, 32'h22,   4'd5},
    '{1'b1, 3'd5, 32'h00,   4'd8},  // R8 no request: 0 free not above 5
    '{1'b1, 3'd0, 32'h00,   4'd11}, // R11 TX data reads 0
    '{1'b1, 3'd7, 32'h00,   4'd11}  // R11 unused address reads 0
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // tasks run from just after a falling edge and return at the next one
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
    reg_rd = 1'b1; reg_addr = a;
    #2;
    chk(tag, reg_rdata, exp);
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic peek(input logic [2:0] a, input logic [31:0] exp, input string tag);
    reg_addr = a;
    #1;
    chk(tag, reg_rdata, exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0;
    eng_tx_pop = 0; eng_rx_push = 0; eng_rx_data = 0;
    evt_pkt_done = 0; evt_all_done = 0; evt_nak = 0; evt_arb_lost = 0;
    repeat (2) @(negedge clk);
    // reset state
    peek(3'd3, 32'h80, "R1 reset fifo status");
    peek(3'd2, 32'h00, "R3 reset control");
    peek(3'd4, 32'h00, "R9 reset mask");
    peek(3'd5, 32'h00, "R4 reset status");
    chk("R9 reset irq", {31'b0, irq}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].rd) rd(VECS[i].addr, VECS[i].data, $sformatf("R%0d vector %0d", VECS[i].req, i));
      else            wr(VECS[i].addr, VECS[i].data);
    end

    // R7 transmit order to engine, dropped word absent
    for (int i = 0; i < 8; i++) begin
      #1;
      chk("R7 tx valid", {31'b0, eng_tx_valid}, 32'h1);
      chk("R7 tx order", eng_tx_data, 32'hB0 + i);
      eng_tx_pop = 1'b1;
      @(negedge clk);
      eng_tx_pop = 1'b0;
    end
    #1;
    chk("R7 overflow word dropped", {31'b0, eng_tx_valid}, 32'h0);

    // R8 receive request above trigger 3
    for (int i = 0; i < 4; i++) begin
      eng_rx_push = 1'b1; eng_rx_data = 32'hC0 + i;
      @(negedge clk);
    end
    eng_rx_push = 1'b0;
    rd(3'd3, 32'h84, "R1 four words received");
    rd(3'd5, 32'h03, "R8 both data requests");
    for (int i = 0; i < 4; i++) rd(3'd1, 32'hC0 + i, "R6 receive order");

    // R9 / R10 mask behaviour
    wr(3'd4, 32'h01);
    #2; chk("R9 irq with masked-in bit", {31'b0, irq}, 32'h1);
    wr(3'd4, 32'h00);
    #2; chk("R9 irq masked out", {31'b0, irq}, 32'h0);
    rd(3'd5, 32'h03, "R10 status kept after unmask");
    wr(3'd5, 32'h03);
    rd(3'd5, 32'h02, "R5 clear, tx request recurs");

    // R4 events
    wr(3'd4, 32'h08);
    evt_nak = 1'b1; @(negedge clk); evt_nak = 1'b0;
    #2; chk("R4 nak raises irq", {31'b0, irq}, 32'h1);
    rd(3'd5, 32'h0A, "R4 nak bit 3");
    wr(3'd5, 32'h08);
    #2; chk("R5 irq drops after clear", {31'b0, irq}, 32'h0);
    evt_pkt_done = 1; evt_all_done = 1; evt_arb_lost = 1;
    @(negedge clk);
    evt_pkt_done = 0; evt_all_done = 0; evt_arb_lost = 0;
    rd(3'd5, 32'hC6, "R4 bits 7 6 2");

    // R5 set and clear in the same cycle
    evt_pkt_done = 1'b1;
    wr(3'd5, 32'h80);
    evt_pkt_done = 1'b0;
    rd(3'd5, 32'hC6, "R5 set wins over clear");
    wr(3'd5, 32'hC4);
    rd(3'd5, 32'h02, "R5 cleared without event");

    // R2 receive flush
    for (int i = 0; i < 2; i++) begin
      eng_rx_push = 1'b1; eng_rx_data = 32'hE0 + i;
      @(negedge clk);
    end
    eng_rx_push = 1'b0;
    wr(3'd2, 32'hAD);
    rd(3'd2, 32'hAD, "R2 rx flush bit visible");
    rd(3'd2, 32'hAC, "R2 rx flush self cleared");
    rd(3'd3, 32'h80, "R2 receive emptied");

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule